// File: doc/BRIEF.md
# Late-Arrival Detecting Pipeline Register

This block is a pipeline register for designs that run their supply voltage close to the failure point. It does not rely on a timing margin. A main flip-flop takes the data input at the clock edge. A second, shadow flip-flop takes the same input again on the rising edge of a delayed strobe, which arrives part way through the following clock period. By the time the strobe fires, data that was late at the clock edge has settled. The two copies are compared at the next clock edge. If they disagree, the main copy was wrong.

On a disagreement, three things happen at that edge:
- The main register is loaded with the shadow value.
- The output is held back for one cycle.
- A one-cycle error pulse is raised, and a saturating error count is incremented. A supply-voltage controller reads this count.

Values leave through a commit stage one edge after they are compared, so the downstream logic never sees a wrong value. The datum offered on the detecting edge is dropped. A stall output asks the upstream stage to offer that datum again.

Top module: `late_catch_reg`

## Requirements
- R1: While reset is low and directly after it, `dout`, `dout_vld`, `timing_err`, `stall_req` and `err_count` are all zero.
- R2: A datum taken by the main register at clock edge k, whose shadow copy agrees, appears on `dout` with `dout_vld` high after edge k+1.
- R3: The shadow copy is the value of `din` at the rising edge of `late_stb`. The strobe pulses exactly once per clock period, after the edge at which the main register took that datum.
- R4: When the main and shadow values disagree at edge k+1, `timing_err` is high for exactly the one cycle after that edge.
- R5: On a disagreement, `dout_vld` is low for the cycle after the detecting edge and `dout` holds its previous value. At the following edge the shadow value is committed on `dout` with `dout_vld` high.
- R6: `stall_req` is high for exactly the one cycle after a detecting edge. The `din` value taken at the detecting edge is discarded, and the upstream stage offers it again during the stall cycle.
- R7: No comparison is made at the first edge after reset, or at the edge that ends a stall cycle.
- R8: No error is raised when the main and shadow values agree, including long runs of unchanging data.
- R9: `err_count` rises by one at every detecting edge, stays unchanged at every other edge, and holds at 2^CNT_W-1 once it reaches it.
- R10: Offered again as R6 requires, the values committed with `dout_vld` high are the settled values of the offered data, in order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | W | Data from the upstream logic |
| late_stb | input | 1 | Delayed sampling strobe, one rising edge per clock period |
| dout | output | W | Committed data |
| dout_vld | output | 1 | `dout` was updated with a checked value at the last edge |
| timing_err | output | 1 | One-cycle pulse per detected late arrival |
| stall_req | output | 1 | Upstream must offer its last datum again |
| err_count | output | CNT_W | Saturating count of detected late arrivals |

## Verification
A datum taken at edge k is compared at edge k+1. If the copies agree, it is visible on `dout` one cycle after edge k+1. If they disagree, `timing_err` and `stall_req` are visible after edge k+1 and the corrected value after edge k+2. The bench updates its model at each rising edge and reads every output 2 ns later, so each result is checked in the cycle in which it is due. Before each edge the bench drives the early value of a datum. It changes to the settled value 4 ns after the edge and pulses the strobe between 6 ns and 8 ns, so the shadow flop always samples after the main flop. Whenever `stall_req` is seen, the bench offers the dropped datum again and compares the committed stream against its own ordered list of settled values.

// File: rtl/late_catch_pkg.sv
`timescale 1ns/1ps
package late_catch_pkg;
  // Stage occupancy / recovery state
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,  // nothing captured yet since reset
    ST_RUN   = 2'd1,  // main holds a datum awaiting comparison
    ST_RECOV = 2'd2   // main was just restored; one stall cycle
  } lc_state_e;
endpackage

// File: rtl/lc_shadow.sv
`timescale 1ns/1ps
module lc_shadow #(
  parameter int W = 16
) (
  input  logic         sample_stb,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Second sample of the data input, taken later in the period.
  always_ff @(posedge sample_stb or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/lc_compare.sv
`timescale 1ns/1ps
module lc_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0] main_val,
  input  logic [W-1:0] late_val,
  output logic         differ
);
  logic [W-1:0] bit_diff;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign bit_diff[g] = main_val[g] ^ late_val[g];
  end

  assign differ = |bit_diff;
endmodule

// File: rtl/lc_ctrl.sv
`timescale 1ns/1ps
module lc_ctrl
  import late_catch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] late_val,
  input  logic         differ,
  output logic [W-1:0] main_val,
  output logic [W-1:0] dout,
  output logic         dout_vld,
  output logic         err_pulse,
  output logic         detect,
  output logic         stall
);
  lc_state_e    state_q, state_d;
  logic [W-1:0] main_q, main_d;
  logic         main_en;
  logic [W-1:0] dout_q;
  logic         dout_en;
  logic         vld_q, vld_d;
  logic         err_q, err_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    main_en = 1'b0;
    main_d  = din;
    dout_en = 1'b0;
    vld_d   = 1'b0;
    err_d   = 1'b0;
    detect  = 1'b0;
    unique case (state_q)
      ST_EMPTY: begin
        main_en = 1'b1;
        state_d = ST_RUN;
      end
      ST_RUN: begin
        main_en = 1'b1;
        if (differ) begin
          main_d  = late_val;
          err_d   = 1'b1;
          detect  = 1'b1;
          state_d = ST_RECOV;
        end else begin
          dout_en = 1'b1;
          vld_d   = 1'b1;
        end
      end
      ST_RECOV: begin
        main_en = 1'b1;
        dout_en = 1'b1;
        vld_d   = 1'b1;
        state_d = ST_RUN;
      end
      default: state_d = ST_EMPTY;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_q <= '0;
    else if (main_en) main_q <= main_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= main_q;
  end

  assign main_val  = main_q;
  assign dout      = dout_q;
  assign dout_vld  = vld_q;
  assign err_pulse = err_q;
  assign stall     = (state_q == ST_RECOV);
endmodule

// File: rtl/lc_errcnt.sv
`timescale 1ns/1ps
module lc_errcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CMAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/late_catch_reg.sv
`timescale 1ns/1ps
module late_catch_reg #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic             late_stb,
  output logic [W-1:0]     dout,
  output logic             dout_vld,
  output logic             timing_err,
  output logic             stall_req,
  output logic [CNT_W-1:0] err_count
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] main_q;
  logic         mismatch;
  logic         detect;

  lc_shadow #(.W(W)) u_shadow (
    .sample_stb (late_stb),
    .rst_n      (rst_n),
    .d          (din),
    .q          (shadow_q)
  );

  lc_compare #(.W(W)) u_cmp (
    .main_val (main_q),
    .late_val (shadow_q),
    .differ   (mismatch)
  );

  lc_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .late_val  (shadow_q),
    .differ    (mismatch),
    .main_val  (main_q),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .err_pulse (timing_err),
    .detect    (detect),
    .stall     (stall_req)
  );

  lc_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (detect),
    .count (err_count)
  );
endmodule

// File: rtl/late_catch_reg_chk.sv
`timescale 1ns/1ps
module late_catch_reg_chk #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     dout,
  input logic             dout_vld,
  input logic             timing_err,
  input logic             stall_req,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_ERR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) timing_err |=> !timing_err); // R4
  AST_ERR_NO_COMMIT:  assert property (@(posedge clk) disable iff (!rst_n) timing_err |-> !dout_vld); // R5
  AST_HOLD_NO_VLD:    assert property (@(posedge clk) disable iff (!rst_n) !dout_vld |-> $stable(dout)); // R5
  AST_RESTORE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) stall_req |=> dout_vld); // R5
  AST_ERR_STALLS:     assert property (@(posedge clk) disable iff (!rst_n) timing_err |-> stall_req); // R6
  AST_STALL_ONE:      assert property (@(posedge clk) disable iff (!rst_n) stall_req |=> !stall_req); // R6
  AST_CNT_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) !timing_err |-> $stable(err_count)); // R9
  AST_CNT_STEP:       assert property (@(posedge clk) disable iff (!rst_n)
                        (timing_err && $past(err_count) != CMAX) |-> err_count == CNT_W'($past(err_count) + 1'b1)); // R9
  AST_CNT_SAT:        assert property (@(posedge clk) disable iff (!rst_n)
                        ($past(err_count) == CMAX) |-> err_count == CMAX); // R9
endmodule

bind late_catch_reg late_catch_reg_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dout       (dout),
  .dout_vld   (dout_vld),
  .timing_err (timing_err),
  .stall_req  (stall_req),
  .err_count  (err_count)
);

// File: tb/test_late_catch_reg.sv
`timescale 1ns/1ps
module test_late_catch_reg;
  localparam int W     = 16;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic [W-1:0]     din;
  logic             late_stb;
  logic [W-1:0]     dout;
  logic             dout_vld;
  logic             timing_err;
  logic             stall_req;
  logic [CNT_W-1:0] err_count;

  int n_vec;
  int n_bad;
  bit done;

  late_catch_reg #(.W(W), .CNT_W(CNT_W)) i_late_catch_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .late_stb   (late_stb),
    .dout       (dout),
    .dout_vld   (dout_vld),
    .timing_err (timing_err),
    .stall_req  (stall_req),
    .err_count  (err_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model state
  logic [W-1:0] m_main, m_dout, m_prev_t;
  bit           m_occ, m_recov, m_vld, m_err;
  int           m_cnt;
  logic [W-1:0] exp_q[$];

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // One clock period: early value before the edge, settled value after it,
  // strobe between them. Returns at edge+9.
  task automatic do_cycle(input logic [W-1:0] e, input logic [W-1:0] t);
    din = e;
    @(posedge clk);
    if (!m_occ) begin
      m_vld = 0; m_err = 0; m_main = e; m_occ = 1; m_recov = 0;
    end else if (m_recov) begin
      m_dout = m_main; m_vld = 1; m_err = 0; m_recov = 0; m_main = e;
    end else if (m_main != m_prev_t) begin
      m_main = m_prev_t; m_vld = 0; m_err = 1; m_recov = 1;
      if (m_cnt < CMAX) m_cnt++;
    end else begin
      m_dout = m_main; m_vld = 1; m_err = 0; m_main = e;
    end
    #2;
    chk("R2 R5 dout", int'(dout), int'(m_dout));
    chk("R2 R5 R7 dout_vld", int'(dout_vld), int'(m_vld));
    chk("R4 R7 R8 timing_err", int'(timing_err), int'(m_err));
    chk("R6 stall_req", int'(stall_req), int'(m_recov));
    chk("R9 err_count", int'(err_count), m_cnt);
    if (m_vld && dout_vld) begin
      if (exp_q.size() > 0) chk("R10 commit order", int'(dout), int'(exp_q.pop_front()));
      else chk("R10 unexpected commit", 1, 0);
    end
    #2 din = t;           // R3: settled value only after the main edge
    #2 late_stb = 1'b1;
    #2 late_stb = 1'b0;
    m_prev_t = t;
    #1;
  endtask

  // Offer one datum, offering it again while a stall is raised (R6)
  task automatic offer(input logic [W-1:0] e, input logic [W-1:0] t);
    exp_q.push_back(t);
    do_cycle(e, t);
    while (stall_req) do_cycle(e, t);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; din = '0; late_stb = 1'b0;
    m_main = '0; m_dout = '0; m_prev_t = '0;
    m_occ = 0; m_recov = 0; m_vld = 0; m_err = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #9;
    // R1: reset state
    chk("R1 dout", int'(dout), 0);
    chk("R1 dout_vld", int'(dout_vld), 0);
    chk("R1 timing_err", int'(timing_err), 0);
    chk("R1 stall_req", int'(stall_req), 0);
    chk("R1 err_count", int'(err_count), 0);
    rst_n = 1'b1;

    // R8: long run of unchanging data, no error
    for (int i = 0; i < 20; i++) offer(16'hA5A5, 16'hA5A5);
    // R2: changing data that is always on time
    for (int i = 0; i < 30; i++) offer(W'(i * 16'h1357 + 3), W'(i * 16'h1357 + 3));
    // R3 R4 R5: isolated late arrivals, one bit and many bits
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] v = W'(16'h0F00 + i * 16'h0111);
      if (i % 4 == 1)      offer(v ^ 16'h0001, v);
      else if (i % 4 == 3) offer(~v, v);
      else                 offer(v, v);
    end
    // R6 R7: every datum late, back to back
    for (int i = 0; i < 20; i++) offer(W'(~(i * 16'h0203)), W'(i * 16'h0203));
    // R9: drive the counter into saturation and beyond
    for (int i = 0; i < 270; i++) offer(W'(i + 16'h4000) ^ 16'h8000, W'(i + 16'h4000));
    chk("R9 saturated", int'(err_count), CMAX);
    // Flush with matching data
    for (int i = 0; i < 4; i++) offer(16'h1234, 16'h1234);
    chk("R10 all but last datum committed", exp_q.size(), 1);
    done = 1;
    finish_run();
  end
endmodule